// File: doc/BRIEF.md
# Tree Arbitration Request Router

This block resolves bus arbitration for a single node once the tree has been identified. Each port carries a role (parent, child or inactive), and the node is told whether it is the root. Requests arrive from the local link and from the child ports. One of them is chosen, and the chosen request is then either granted here or passed up the tree.

A root node, or a node with no active ports, grants the chosen request locally. Any other node forwards it toward the root by driving a request code on its parent port. Every other active port, except the winner's own port, is driven with the data prefix code. That code tells the device on that port that its request has been refused. A winner keeps its place for as long as it keeps requesting. It is released one cycle after it withdraws.

Top module: `arb_router`

## Requirements
- R1: After reset, and while nothing is chosen, `grant_o` is 0, `fwd_o` is 0 and every port line is idle (00).
- R2: On a root node (`is_root_i`=1), the edge after a request is sampled sets the `grant_o` bit of the winner to one. Bit i is child port i and bit NPORTS is the local link. Every other active port is driven with the data prefix code 01.
- R3: On a non-root node that has at least one active port, a chosen request sets `fwd_o`=1 and keeps `grant_o`=0. The port whose role is parent (role code 10) is driven with the request code 10. All other active ports, except the winner's, are driven with 01.
- R4: A port whose role is inactive (role code 00) is always driven with 00.
- R5: When several requests are pending, the lowest-numbered child port (role code 01) wins. The local link has the lowest priority.
- R6: A winner stays chosen while its request stays high, even if a request of higher priority arrives.
- R7: The edge after the winner drops its request, the winner is released. The pending request of highest priority is chosen at that same edge.
- R8: A node with no active ports grants a local link request with `fwd_o`=0 and all lines at 00.
- R9: Requests on ports whose role is parent or inactive are ignored and never win.
- R10: The port of a winning child is driven with 00, not with the prefix code.

Each line code is a 2-bit field. Port i occupies bits [2i+1:2i] of `port_role_i` and of `line_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| is_root_i | input | 1 | Node is the tree root |
| port_role_i | input | 2*NPORTS | Role per port: 00 inactive, 01 child, 10 parent |
| link_req_i | input | 1 | Arbitration request from the local link |
| port_req_i | input | NPORTS | Arbitration request sensed on each port |
| grant_o | output | NPORTS+1 | One-hot local grant; bit NPORTS is the link |
| fwd_o | output | 1 | Chosen request is being forwarded to the parent |
| line_o | output | 2*NPORTS | Line code per port: 00 idle, 01 prefix, 10 request |

## Verification
The hardest situation to reach is a held winner that must resist a request of higher priority and must then hand over cleanly to it. The stimulus builds this up in stages. It first lets the link win alone. It then raises a request on child port 0 while the link still holds, and checks that the grant does not move. Finally it drops the link request and expects port 0 on the very next edge. Requests on parent and inactive ports are also driven on their own, to show that nothing is chosen and the lines stay idle.

// File: rtl/arb_router_pkg.sv
package arb_router_pkg;
  localparam logic [1:0] ROLE_OFF    = 2'b00;
  localparam logic [1:0] ROLE_CHILD  = 2'b01;
  localparam logic [1:0] ROLE_PARENT = 2'b10;

  typedef enum logic [1:0] {
    LINE_IDLE   = 2'b00,
    LINE_PREFIX = 2'b01,
    LINE_REQ    = 2'b10
  } line_code_e;
endpackage

// File: rtl/arb_role_decode.sv
module arb_role_decode
  import arb_router_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic [NPORTS-1:0][1:0] role_i,
  output logic [NPORTS-1:0]      child_o,
  output logic [NPORTS-1:0]      parent_o,
  output logic [NPORTS-1:0]      active_o,
  output logic                   isolated_o
);
  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    assign child_o[i]  = (role_i[i] == ROLE_CHILD);
    assign parent_o[i] = (role_i[i] == ROLE_PARENT);
    assign active_o[i] = child_o[i] | parent_o[i];
  end
  assign isolated_o = ~|active_o;
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int NREQ = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREQ-1:0] req_i,
  output logic [NREQ-1:0] win_o
);
  logic [NREQ-1:0] win_q, win_d, lowest;
  logic            hold;

  // isolate lowest set bit
  assign lowest = req_i & (~req_i + NREQ'(1));
  assign hold   = |(win_q & req_i);
  assign win_d  = hold ? win_q : lowest;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win_d;
  end

  assign win_o = win_q;
endmodule

// File: rtl/arb_line_drive.sv
module arb_line_drive
  import arb_router_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic [NPORTS-1:0]      active_i,
  input  logic [NPORTS-1:0]      parent_i,
  input  logic [NPORTS-1:0]      win_port_i,
  input  logic                   any_win_i,
  input  logic                   fwd_i,
  output logic [NPORTS-1:0][1:0] line_o
);
  for (genvar i = 0; i < NPORTS; i++) begin : g_line
    always_comb begin
      if (!active_i[i] || !any_win_i || win_port_i[i]) line_o[i] = LINE_IDLE;
      else if (fwd_i && parent_i[i])                   line_o[i] = LINE_REQ;
      else                                              line_o[i] = LINE_PREFIX;
    end
  end
endmodule

// File: rtl/arb_router.sv
module arb_router
  import arb_router_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   is_root_i,
  input  logic [NPORTS-1:0][1:0] port_role_i,
  input  logic                   link_req_i,
  input  logic [NPORTS-1:0]      port_req_i,
  output logic [NPORTS:0]        grant_o,
  output logic                   fwd_o,
  output logic [NPORTS-1:0][1:0] line_o
);
  localparam int NREQ = NPORTS + 1;

  logic [NPORTS-1:0] child, parent, active;
  logic              isolated, local_mode, any_win;
  logic [NREQ-1:0]   req, win;

  arb_role_decode #(.NPORTS(NPORTS)) u_dec (
    .role_i     (port_role_i),
    .child_o    (child),
    .parent_o   (parent),
    .active_o   (active),
    .isolated_o (isolated)
  );

  assign req = {link_req_i, port_req_i & child};

  arb_pick #(.NREQ(NREQ)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .win_o  (win)
  );

  assign any_win    = |win;
  assign local_mode = is_root_i | isolated;
  assign fwd_o      = any_win & ~local_mode;
  assign grant_o    = local_mode ? win : '0;

  arb_line_drive #(.NPORTS(NPORTS)) u_line (
    .active_i   (active),
    .parent_i   (parent),
    .win_port_i (win[NPORTS-1:0]),
    .any_win_i  (any_win),
    .fwd_i      (fwd_o),
    .line_o     (line_o)
  );
endmodule

// File: rtl/arb_router_chk.sv
module arb_router_chk #(
  parameter int NPORTS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   is_root_i,
  input logic [NPORTS-1:0][1:0] port_role_i,
  input logic                   link_req_i,
  input logic [NPORTS-1:0]      port_req_i,
  input logic [NPORTS:0]        grant_o,
  input logic                   fwd_o,
  input logic [NPORTS-1:0][1:0] line_o
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  // R3
  fwd_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> (grant_o == '0));

  // R8
  isolated_no_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_role_i == '0) |-> !fwd_o);

  // R6
  link_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(grant_o[NPORTS]) && $past(link_req_i) && $stable(port_role_i)
     && $stable(is_root_i)) |-> grant_o[NPORTS]);

  // R7
  link_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(grant_o[NPORTS]) && !$past(link_req_i)) |-> !grant_o[NPORTS]);

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    // R4
    inactive_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_role_i[i] == 2'b00) |-> (line_o[i] == 2'b00));
    // R9
    nonchild_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_role_i[i] != 2'b01 && $past(port_role_i[i]) != 2'b01) |-> !grant_o[i]);
  end
endmodule

bind arb_router arb_router_chk #(.NPORTS(NPORTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .is_root_i   (is_root_i),
  .port_role_i (port_role_i),
  .link_req_i  (link_req_i),
  .port_req_i  (port_req_i),
  .grant_o     (grant_o),
  .fwd_o       (fwd_o),
  .line_o      (line_o)
);

// File: tb/arb_router_tb.sv
module arb_router_tb;
  localparam int NPORTS = 4;
  localparam int CLK_PERIOD = 10;

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   is_root_i = 1'b0;
  logic [NPORTS-1:0][1:0] port_role_i = '0;
  logic                   link_req_i = 1'b0;
  logic [NPORTS-1:0]      port_req_i = '0;
  logic [NPORTS:0]        grant_o;
  logic                   fwd_o;
  logic [NPORTS-1:0][1:0] line_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  arb_router #(.NPORTS(NPORTS)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply inputs, then sample after the next rising edge
  task automatic step(input logic lreq, input logic [NPORTS-1:0] preq);
    @(negedge clk_i);
    link_req_i = lreq;
    port_req_i = preq;
    @(posedge clk_i);
    #1;
  endtask

  task automatic clear();
    step(1'b0, '0);
    chk("R1 idle grant", 32'(grant_o), 0);
  endtask

  task automatic t_reset();
    chk("R1 grant", 32'(grant_o), 0);
    chk("R1 fwd", 32'(fwd_o), 0);
    chk("R1 line", 32'(line_o), 0);
  endtask

  task automatic t_root_single();
    @(negedge clk_i);
    is_root_i = 1'b1;
    port_role_i = {2'b00, 2'b01, 2'b01, 2'b01};
    step(1'b0, 4'b0100);
    chk("R2 grant", 32'(grant_o), 32'b00100);
    chk("R10 R4 R2 line", 32'(line_o), 32'b00_00_01_01);
    chk("R2 fwd", 32'(fwd_o), 0);
    clear();
  endtask

  task automatic t_priority();
    step(1'b1, 4'b0110);
    chk("R5 lowest child", 32'(grant_o), 32'b00010);
    step(1'b1, 4'b0100);
    chk("R7 next child", 32'(grant_o), 32'b00100);
    step(1'b1, 4'b0000);
    chk("R7 link last", 32'(grant_o), 32'b10000);
    chk("R2 line link", 32'(line_o), 32'b00_01_01_01);
  endtask

  task automatic t_hold();
    step(1'b1, 4'b0001);
    chk("R6 hold link", 32'(grant_o), 32'b10000);
    step(1'b0, 4'b0001);
    chk("R7 handover", 32'(grant_o), 32'b00001);
    clear();
  endtask

  task automatic t_nonroot();
    @(negedge clk_i);
    is_root_i = 1'b0;
    port_role_i = {2'b00, 2'b01, 2'b01, 2'b10};
    step(1'b1, 4'b0000);
    chk("R3 fwd", 32'(fwd_o), 1);
    chk("R3 grant", 32'(grant_o), 0);
    chk("R3 line", 32'(line_o), 32'b00_01_01_10);
    clear();
    step(1'b0, 4'b1001);
    chk("R9 fwd", 32'(fwd_o), 0);
    chk("R9 line", 32'(line_o), 0);
    step(1'b0, 4'b0100);
    chk("R10 child fwd line", 32'(line_o), 32'b00_00_01_10);
    chk("R3 child fwd", 32'(fwd_o), 1);
    clear();
  endtask

  task automatic t_isolated();
    @(negedge clk_i);
    port_role_i = '0;
    step(1'b1, 4'b1111);
    chk("R8 grant", 32'(grant_o), 32'b10000);
    chk("R8 line", 32'(line_o), 0);
    chk("R8 fwd", 32'(fwd_o), 0);
    clear();
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_root_single();
    t_priority();
    t_hold();
    t_nonroot();
    t_isolated();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule